// File: doc/BRIEF.md
# Converter serial port with data-ready flag

This block is the digital host port of a sampling converter. The port has one data output pin, and that pin is also the "result ready" flag. A host writes 8-bit command bytes on the serial input. Each bit is sampled on a rising edge of the serial clock, most significant bit first. The continuous command starts a word-rate timer that runs on the master clock. Each time the timer expires, one conversion is complete. The result of that conversion is taken from a 24-bit input bus, and the output pin is pulled low.

To read the result, the host clocks eight zero bits. This clears the flag. On the falling edge of the eighth of these clocks, the pin shows the result's top bit. Twenty-four more clocks then shift out the rest of the word. A host may leave a result unread. In that case the flag goes high for one master clock just before the next result and then drops again. A valid command sent while the flag is low leaves continuous mode.

The serial clock and data pins are synchronised into the master-clock domain, and their edges are detected there. For this reason the serial clock must run well below the master clock: each of its phases must last at least three master clocks.

Top module: `cnv_serial_port`

## Requirements
- R1: After reset, and in the idle state, `sdo` is 1 and no conversion runs. The block stays idle until a continuous command arrives.
- R2: The byte 0xC0 (bits 7 and 6 set) is the continuous command. Once it is received, conversions repeat, and the completion of each one latches `conv_data` and drives `sdo` to 0.
- R3: With the flag low, eight clocks with `sdi` at 0 clear the flag. After the falling edge of the eighth clock, `sdo` holds bit 23 of the latched word.
- R4: The next 24 clocks present bits 22 down to 0 on `sdo`, one bit after each of the first 23 falling edges. After the 24th falling edge `sdo` returns to 1 and the port waits for the next conversion.
- R5: The conversion interval is `BASE_DIV << rate_sel` master clocks. With the default `BASE_DIV` of 2184, code 0 gives about 15 words per second from a 32.768 kHz master clock.
- R6: If a result is not read, `sdo` goes to 1 for exactly one master clock before the next conversion completes. It then falls again, and the new word is latched.
- R7: A conversion that completes after a flag-clear has begun, or during a read, is discarded. The read delivers the word that was latched when the flag fell.
- R8: The halt command, 0x80, received while the flag is low (or while waiting), stops conversions and sets `sdo` to 1.
- R9: A continuous command received while a conversion is in progress restarts the full interval from that command.
- R10: While a result is being read, the bits on `sdi` are not decoded as commands.
- R11: A byte that is neither 0xC0, nor 0x80, nor (while the flag is low) 0x00 has no effect. In particular, a low flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | RATE_W | Word-rate code (interval = BASE_DIV << code) |
| conv_data | input | DATA_W | Conversion result, latched when a conversion completes |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command/data input |
| sdo | output | 1 | Serial data output and active-low ready flag |

## Verification
The hardest cases to reach from the pins are the ones where the serial transfer and the background timer overlap:
- a conversion that completes while a flag-clear is under way;
- the one-cycle re-arm pulse before an unread word;
- a restart partway through an interval.

The bench sets the shortest interval, which is shorter than one serial byte, so that every clear and every read is overlapped by a conversion completion. It changes `conv_data` immediately after each flag falls, so a discarded word shows up as a wrong value in the read. It counts master clocks between flag edges to measure the pulse width, the interval and the restart delay.

// File: rtl/cnv_port_pkg.sv
package cnv_port_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_FLAG,
      ST_READ
   } port_st_e;

   localparam int CMD_W = 8;
   localparam logic [CMD_W-1:0] CMD_CONT = 8'hC0;
   localparam logic [CMD_W-1:0] CMD_HALT = 8'h80;
   localparam logic [CMD_W-1:0] CMD_CLR  = 8'h00;
endpackage

// File: rtl/cnv_pin_sync.sv
module cnv_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdi_i,
   output logic sclk_lvl,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic sdi_lvl
);
   logic [STAGES-1:0] sc_q;
   logic [STAGES-1:0] sd_q;
   logic              sc_last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cnv_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q    <= '0;
         sd_q    <= '0;
         sc_last <= 1'b0;
      end else begin
         sc_q    <= {sc_q[STAGES-2:0], sclk_i};
         sd_q    <= {sd_q[STAGES-2:0], sdi_i};
         sc_last <= sc_q[STAGES-1];
      end
   end

   assign sclk_lvl  = sc_q[STAGES-1];
   assign sdi_lvl   = sd_q[STAGES-1];
   assign sclk_rise = sc_q[STAGES-1] & ~sc_last;
   assign sclk_fall = ~sc_q[STAGES-1] & sc_last;
endmodule

// File: rtl/cnv_rate_timer.sv
module cnv_rate_timer #(
   parameter int BASE_DIV = 2184,
   parameter int RATE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              done,
   output logic              pre
);
   localparam int CNT_W = $clog2(BASE_DIV) + (1 << RATE_W) + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] span;
   logic [CNT_W-1:0] last;

   generate
      if (BASE_DIV < 4) begin : g_bad_div
         $error("cnv_rate_timer: BASE_DIV must be at least 4");
      end
   endgenerate

   assign span = CNT_W'(BASE_DIV) << rate_sel;
   assign last = span - CNT_W'(1);
   assign done = run && (cnt >= last);
   assign pre  = run && (cnt == last - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || restart) cnt <= '0;
      else if (done)            cnt <= '0;
      else                      cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/cnv_serial_port.sv
module cnv_serial_port
   import cnv_port_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int RATE_W      = 3,
   parameter int BASE_DIV    = 2184,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo
);
   localparam int RD_W = $clog2(DATA_W + 1);
   localparam logic [RD_W-1:0] RD_LAST = RD_W'(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cnv_serial_port: DATA_W must be at least 2");
      end
   endgenerate

   port_st_e          st;
   logic              sclk_lvl, sclk_rise, sclk_fall, sdi_lvl;
   logic              conv_done, pre_done, restart, busy, byte_end;
   logic [2:0]        bit_cnt;
   logic [6:0]        byte_sr;
   logic [CMD_W-1:0]  cmd_byte;
   logic              sdo_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] shreg;
   logic [RD_W-1:0]   rd_cnt;

   cnv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .sdi_i     (sdi),
      .sclk_lvl  (sclk_lvl),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .sdi_lvl   (sdi_lvl)
   );

   cnv_rate_timer #(.BASE_DIV(BASE_DIV), .RATE_W(RATE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (st != ST_IDLE),
      .restart  (restart),
      .rate_sel (rate_sel),
      .done     (conv_done),
      .pre      (pre_done)
   );

   assign cmd_byte = {byte_sr, sdi_lvl};
   assign byte_end = sclk_rise && (bit_cnt == 3'd7) && (st != ST_READ);
   assign restart  = byte_end && (cmd_byte == CMD_CONT) &&
                     ((st == ST_WAIT) || (st == ST_FLAG));
   assign busy     = (bit_cnt != 3'd0) || sclk_lvl;
   assign sdo      = sdo_q;

   // command byte assembly; frozen while a read owns the clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         byte_sr <= '0;
      end else if (sclk_rise && (st != ST_READ)) begin
         bit_cnt <= bit_cnt + 3'd1;
         byte_sr <= {byte_sr[5:0], sdi_lvl};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sdo_q  <= 1'b1;
         data_q <= '0;
         shreg  <= '0;
         rd_cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (byte_end && (cmd_byte == CMD_CONT)) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (byte_end && (cmd_byte == CMD_HALT)) begin
                  st <= ST_IDLE;
               end else if (conv_done && !restart) begin
                  data_q <= conv_data;
                  sdo_q  <= 1'b0;
                  st     <= ST_FLAG;
               end
            end
            ST_FLAG: begin
               if (byte_end) begin
                  if (cmd_byte == CMD_CLR) begin
                     st     <= ST_READ;
                     shreg  <= data_q;
                     rd_cnt <= '0;
                  end else if (cmd_byte == CMD_CONT) begin
                     st    <= ST_WAIT;
                     sdo_q <= 1'b1;
                  end else if (cmd_byte == CMD_HALT) begin
                     st    <= ST_IDLE;
                     sdo_q <= 1'b1;
                  end
               end else if (conv_done && (!busy || sdo_q)) begin
                  data_q <= conv_data;
                  sdo_q  <= 1'b0;
               end else if (pre_done && !busy) begin
                  sdo_q <= 1'b1;
               end
            end
            ST_READ: begin
               if (sclk_fall) begin
                  if (rd_cnt == RD_LAST) begin
                     sdo_q  <= 1'b1;
                     st     <= ST_WAIT;
                     rd_cnt <= '0;
                  end else begin
                     sdo_q  <= shreg[DATA_W-1];
                     shreg  <= {shreg[DATA_W-2:0], 1'b1};
                     rd_cnt <= rd_cnt + RD_W'(1);
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cnv_port_chk.sv
module cnv_port_chk
   import cnv_port_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     sdo,
   input port_st_e st,
   input logic     conv_done,
   input logic     byte_end
);
   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> sdo);

   p_flag_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && conv_done && !byte_end) |=> (!sdo && st == ST_FLAG));

   p_read_exit_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && $past(st) == ST_READ) |-> sdo);

   p_rearm_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FLAG && $rose(sdo)) |=> (!sdo || st != ST_FLAG));

   p_read_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_READ) |=> (st == ST_READ || st == ST_WAIT));
endmodule

bind cnv_serial_port cnv_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sdo       (sdo),
   .st        (st),
   .conv_done (conv_done),
   .byte_end  (byte_end)
);

// File: tb/cnv_serial_port_test.sv
`timescale 1ns/1ps
module cnv_serial_port_test;
   localparam int DW   = 24;
   localparam int RW   = 3;
   localparam int BDIV = 64;

   logic          clk = 1'b0;
   logic          rst_n, sclk, sdi, sdo;
   logic [RW-1:0] rate_sel;
   logic [DW-1:0] conv_data;
   int            n_chk = 0;
   int            n_fail = 0;
   int            cyc_all = 0;

   // rate code (3 bits) and conversion word (24 bits) per vector
   localparam logic [26:0] VEC [4] = '{
      {3'd0, 24'hA5F00F},
      {3'd1, 24'h800001},
      {3'd2, 24'h7FFFFE},
      {3'd3, 24'h3C5A96}
   };

   always #2.5 clk = ~clk;

   cnv_serial_port #(.DATA_W(DW), .RATE_W(RW), .BASE_DIV(BDIV)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_sel  (rate_sel),
      .conv_data (conv_data),
      .sclk      (sclk),
      .sdi       (sdi),
      .sdo       (sdo)
   );

   always @(posedge clk) begin
      cyc_all++;
      if (cyc_all == 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      sdi = b;
      tick(3);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic wait_flag(output int cyc, input int limit);
      cyc = 0;
      while (sdo !== 1'b0 && cyc < limit) begin
         tick(1);
         cyc++;
      end
   endtask

   task automatic watch_high(input int n, output int lows);
      lows = 0;
      repeat (n) begin
         tick(1);
         if (sdo !== 1'b1) lows++;
      end
   endtask

   task automatic read_word(output logic [23:0] w, output logic endh, input logic [23:0] junk);
      for (int i = 0; i < 8; i++) send_bit(1'b0);
      w[23] = sdo;
      for (int i = 1; i < 24; i++) begin
         send_bit(junk[24-i]);
         w[23-i] = sdo;
      end
      send_bit(junk[0]);
      endh = sdo;
   endtask

   initial begin
      int          cyc, lows, t, wd;
      logic [23:0] w;
      logic        endh;
      rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; rate_sel = '0; conv_data = '0;
      tick(5);
      chk("R1 reset sdo", sdo, 1);
      rst_n = 1'b1;
      watch_high(300, lows);
      chk("R1 idle no flag", lows, 0);

      for (int v = 0; v < 4; v++) begin
         rate_sel  = VEC[v][26:24];
         conv_data = VEC[v][23:0];
         send_byte(8'hC0);
         wait_flag(cyc, 4000);
         chk("R2 flag low", sdo, 0);
         read_word(w, endh, 24'h0);
         chk("R3 msb", w[23], VEC[v][23]);
         chk("R4 word", w, VEC[v][23:0]);
         chk("R4 sdo high after read", endh, 1);
         send_byte(8'h80);
         watch_high(2 * (BDIV << VEC[v][26:24]), lows);
         chk("R8 halted", lows, 0);
      end

      // skip a read: re-arm pulse, interval, discard during clear
      rate_sel = 3'd0;
      conv_data = 24'h123456;
      send_byte(8'hC0);
      wait_flag(cyc, 2000);
      conv_data = 24'hABCDEF;
      t = 0;
      while (sdo !== 1'b1 && t < 1000) begin tick(1); t++; end
      wd = 0;
      while (sdo !== 1'b0 && wd < 1000) begin tick(1); wd++; end
      chk("R6 pulse width", wd, 1);
      chk("R5 interval", t + wd, BDIV);
      conv_data = 24'h0F0F0F;
      read_word(w, endh, 24'h0);
      chk("R7 word kept", w, 24'hABCDEF);
      wait_flag(cyc, 2000);
      read_word(w, endh, 24'h0);
      chk("R7 later word", w, 24'h0F0F0F);
      send_byte(8'h80);
      tick(20);

      // restart mid-conversion
      rate_sel = 3'd3;
      conv_data = 24'h5A5A5A;
      send_byte(8'hC0);
      tick(200);
      send_byte(8'hC0);
      wait_flag(cyc, 2000);
      chk("R9 restart delay", (cyc >= 500 && cyc <= 510), 1);
      read_word(w, endh, 24'h0);
      chk("R9 word", w, 24'h5A5A5A);
      send_byte(8'h80);
      tick(20);

      // exit from continuous mode while flag low
      rate_sel = 3'd1;
      send_byte(8'hC0);
      wait_flag(cyc, 2000);
      send_byte(8'h80);
      chk("R8 sdo after halt", sdo, 1);
      watch_high(400, lows);
      chk("R8 no further flag", lows, 0);

      // unknown bytes and suppressed decode during read
      send_byte(8'h5A);
      watch_high(300, lows);
      chk("R11 idle unknown", lows, 0);
      rate_sel = 3'd3;
      conv_data = 24'hC3E1F0;
      send_byte(8'hC0);
      wait_flag(cyc, 2000);
      send_byte(8'h5A);
      chk("R11 flag held", sdo, 0);
      read_word(w, endh, 24'h80C080);
      chk("R10 word", w, 24'hC3E1F0);
      wait_flag(cyc, 1200);
      chk("R10 still running", sdo, 0);
      send_byte(8'h80);
      tick(20);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule